// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block is the interrupt register group of a serial port. Eleven event sources feed it: receive, transmit, receive timeout, four modem-status changes and four line errors. A single-cycle pulse on an event input latches the matching raw status bit. Software chooses which raw bits may raise interrupts by writing a mask register. It can read the raw status, the mask and the masked status (raw AND mask), and it removes raw bits by writing ones to a clear register. A write to the transmit data address also latches the transmit bit.

The masked status drives six registered interrupt lines. Five lines each serve one group: receive, transmit, receive timeout, modem status and errors. The sixth line is the OR of all five. The datapath that detects the events lies outside this block. This block only holds the status and routes it.

Top module: `uart_irq_router`

## Requirements
- R1: After reset, raw status, mask, read data and all six interrupt lines are zero.
- R2: Raw status bit layout: bit 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break error, 10 overrun error. A read of the masked-status address returns raw AND mask.
- R3: A write to the clear address clears every raw bit that is 1 in the written value and leaves the other bits unchanged. A read of the clear address returns 0.
- R4: Writes to the raw-status and masked-status addresses leave raw status and mask unchanged.
- R5: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A write to the data address sets raw bit 5 (transmit).
- R7: The combined line is high exactly when any masked bit 0..10 is set. It follows the status and the mask with one cycle of register delay.
- R8: Group lines, each one cycle behind the status: receive = masked bit 4; transmit = masked bit 5; timeout = masked bit 6; modem = OR of masked bits 0..3; error = OR of masked bits 7..10.
- R9: Register addresses: 0 data, 1 mask, 2 raw status, 3 masked status, 4 clear. A mask write stores write-data bits 10:0. Read data appears, zero-extended, on the cycle after the read address is presented and shows the state before that edge. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address, sampled every cycle |
| rd_data | output | 16 | Registered read data |
| evt_set | input | 11 | Event pulses, one per raw status bit |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rto | output | 1 | Receive-timeout interrupt line |
| irq_modem | output | 1 | Modem-status group line |
| irq_err | output | 1 | Error group line |

## Verification
The bench builds the block with its default 16-bit data and 3-bit address widths. These widths are enough to reach every one of the eleven status bits, the upper write-data bits that the mask must drop, and the unused addresses 5 to 7. With these values, a walk of one bit at a time across the full layout checks each group line in isolation. The same values allow a clear write and an event on the same bit in one cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC   = 11;
    localparam int NGRP   = 5;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    localparam int BIT_TX = 5;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_RAW  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

    // group order on the grp vector: 0 rx, 1 tx, 2 timeout, 3 modem, 4 error
    localparam logic [NSRC-1:0] GM_RX  = 11'h010;
    localparam logic [NSRC-1:0] GM_TX  = 11'h020;
    localparam logic [NSRC-1:0] GM_RTO = 11'h040;
    localparam logic [NSRC-1:0] GM_MS  = 11'h00F;
    localparam logic [NSRC-1:0] GM_ERR = 11'h780;

    typedef struct packed {
        logic [NSRC-1:0] raw;
        logic [NSRC-1:0] mask;
    } irq_regs_t;

    typedef struct packed {
        logic            any;
        logic [NGRP-1:0] grp;
    } irq_lines_t;
endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
    import uart_irq_pkg::*;
#(
    parameter int NS  = NSRC,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NS-1:0] evt_set,
    output logic [NS-1:0] raw_q,
    output logic [NS-1:0] mask_q
);
    irq_regs_t     st_d, st_q;
    logic [NS-1:0] set_vec;
    logic [NS-1:0] clr_vec;

    always_comb begin
        set_vec = evt_set;
        if (wr_en && wr_addr == A_DATA) begin
            set_vec[BIT_TX] = 1'b1;
        end
        clr_vec = (wr_en && wr_addr == A_CLR) ? wr_data[NS-1:0] : '0;
        st_d      = st_q;
        st_d.raw  = (st_q.raw & ~clr_vec) | set_vec;
        if (wr_en && wr_addr == A_MASK) begin
            st_d.mask = wr_data[NS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;

    // R5: every pulsed bit is present next cycle, clear or not
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    // R3: cleared bits without a concurrent set are gone
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

    // R4: writes to status views change nothing
    p_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_RAW || wr_addr == A_MSK) && !(|evt_set))
        |=> (raw_q == $past(raw_q) && mask_q == $past(mask_q)));
endmodule

// File: rtl/uirq_route.sv
module uirq_route
    import uart_irq_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int NG = NGRP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] raw,
    input  logic [NS-1:0] mask,
    output logic          any_q,
    output logic [NG-1:0] grp_q
);
    localparam logic [NG-1:0][NS-1:0] GMAP = {GM_ERR, GM_MS, GM_RTO, GM_TX, GM_RX};

    irq_lines_t    ln_d, ln_q;
    logic [NS-1:0] masked;
    logic [NG-1:0] grp_hit;

    assign masked = raw & mask;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_hit[g] = |(masked & GMAP[g]);

        // R8: each group line tracks its bits one cycle later
        p_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (grp_q[g] == |($past(raw & mask) & GMAP[g])));
    end

    always_comb begin
        ln_d     = ln_q;
        ln_d.grp = grp_hit;
        ln_d.any = |masked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign any_q = ln_q.any;
    assign grp_q = ln_q.grp;

    // R7: combined line agrees with the group lines
    p_combined_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_q == (|grp_q));
endmodule

// File: rtl/uirq_rdmux.sv
module uirq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [NS-1:0] raw,
    input  logic [NS-1:0] mask,
    output logic [DW-1:0] rd_data_q
);
    logic [DW-1:0] rd_data_d;

    always_comb begin
        rd_data_d = '0;
        unique case (rd_addr)
            A_MASK:  rd_data_d[NS-1:0] = mask;
            A_RAW:   rd_data_d[NS-1:0] = raw;
            A_MSK:   rd_data_d[NS-1:0] = raw & mask;
            default: rd_data_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    // R3: the clear address always reads zero
    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CLR) |=> (rd_data_q == '0));

    // R2: masked view equals raw AND mask
    p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MSK) |=> (rd_data_q[NS-1:0] == $past(raw & mask)));
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
    import uart_irq_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [NS-1:0] evt_set,
    output logic          irq_any,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          irq_rto,
    output logic          irq_modem,
    output logic          irq_err
);
    logic [NS-1:0]   raw_q, mask_q;
    logic [NGRP-1:0] grp;

    uirq_regs #(.NS(NS), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_set(evt_set), .raw_q(raw_q), .mask_q(mask_q)
    );

    uirq_route #(.NS(NS), .NG(NGRP)) u_route (
        .clk(clk), .rst_n(rst_n), .raw(raw_q), .mask(mask_q),
        .any_q(irq_any), .grp_q(grp)
    );

    uirq_rdmux #(.NS(NS), .AW(AW), .DW(DW)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .raw(raw_q),
        .mask(mask_q), .rd_data_q(rd_data)
    );

    assign irq_rx    = grp[0];
    assign irq_tx    = grp[1];
    assign irq_rto   = grp[2];
    assign irq_modem = grp[3];
    assign irq_err   = grp[4];

    // R1: lines quiet in the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_any && grp == '0 && rd_data == '0));
endmodule

// File: tb/tb_uart_irq_router.sv
module tb_uart_irq_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [10:0] evt_set = '0;
    logic        irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

    int checks = 0;
    int fails  = 0;
    int m_raw  = 0;
    int m_mask = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_router dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_set(evt_set), .irq_any(irq_any), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rto(irq_rto), .irq_modem(irq_modem),
        .irq_err(irq_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive inputs, advance the model, compare all outputs
    task automatic step(input string tag, input bit we, input int wa, input int wd,
                        input int ra, input int ev);
        int m, e_rd, nraw;
        wr_en = we; wr_addr = wa[2:0]; wr_data = wd[15:0];
        rd_addr = ra[2:0]; evt_set = ev[10:0];
        @(posedge clk);
        m = m_raw & m_mask;
        case (ra)
            1: e_rd = m_mask;
            2: e_rd = m_raw;
            3: e_rd = m;
            default: e_rd = 0;
        endcase
        nraw = m_raw;
        if (we && wa == 4) nraw = nraw & ~(wd & 'h7FF);
        nraw = nraw | ev;
        if (we && wa == 0) nraw = nraw | 'h20;
        if (we && wa == 1) m_mask = wd & 'h7FF;
        m_raw = nraw;
        #1;
        chk(tag, "rd_data", int'(rd_data), e_rd);
        chk({tag, " R7"}, "irq_any", int'(irq_any), int'(m != 0));
        chk({tag, " R8"}, "irq_rx", int'(irq_rx), (m >> 4) & 1);
        chk({tag, " R8"}, "irq_tx", int'(irq_tx), (m >> 5) & 1);
        chk({tag, " R8"}, "irq_rto", int'(irq_rto), (m >> 6) & 1);
        chk({tag, " R8"}, "irq_modem", int'(irq_modem), int'((m & 'hF) != 0));
        chk({tag, " R8"}, "irq_err", int'(irq_err), int'((m & 'h780) != 0));
        wr_en = 1'b0; evt_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        step("R1", 0, 0, 0, 2, 0);
        step("R1", 0, 0, 0, 1, 0);
        // all events, nothing masked: lines quiet
        step("R7", 0, 0, 0, 2, 'h7FF);
        step("R2", 0, 0, 0, 2, 0);
        // R9: mask write keeps only bits 10:0, reads back
        step("R9", 1, 1, 'hF810, 1, 0);
        step("R9", 0, 0, 0, 1, 0);
        step("R2", 0, 0, 0, 3, 0);
        step("R9", 0, 0, 0, 5, 0);
        // R3: clear selected bits, then read clear address
        step("R3", 1, 4, 'h0F0, 2, 0);
        step("R3", 0, 0, 0, 2, 0);
        step("R3", 0, 0, 0, 4, 0);
        // R4: writes to raw and masked addresses ignored
        step("R4", 1, 2, 'h000, 2, 0);
        step("R4", 1, 3, 'h7FF, 2, 0);
        step("R4", 0, 0, 0, 1, 0);
        // R5: set and clear on the same bit
        step("R5", 1, 4, 'h7FF, 2, 'h010);
        step("R5", 0, 0, 0, 2, 0);
        step("R5", 0, 0, 0, 3, 0);
        // R6: data write sets transmit bit
        step("R6", 1, 0, 'h0041, 2, 0);
        step("R6", 0, 0, 0, 2, 0);
        // R7 R8: walk each bit alone with full mask
        step("R8", 1, 1, 'h7FF, 1, 0);
        for (int i = 0; i < 11; i++) begin
            step("R8", 1, 4, 'h7FF, 2, 0);
            step("R8", 0, 0, 0, 2, 1 << i);
            step("R8", 0, 0, 0, 3, 0);
            step("R7", 0, 0, 0, 2, 0);
        end
        // R2: partial mask over mixed status
        step("R2", 1, 1, 'h2A5, 3, 'h5C3);
        step("R2", 0, 0, 0, 3, 0);
        step("R2", 0, 0, 0, 3, 0);
        step("R7", 1, 1, 'h000, 3, 0);
        step("R7", 0, 0, 0, 3, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule